// File: doc/BRIEF.md
# Synchronous Character Transmitter with Automatic Gap Fill

This block serialises 5- to 8-bit characters for a character-oriented synchronous link. The CPU side writes one character at a time into a single holding register, guided by a ready flag. The link side supplies a one-cycle bit strobe, and the block moves exactly one bit onto `txd` per strobe, least significant bit first, with an optional parity bit after the data. Once the first character has gone out, the line never idles. If the CPU has not supplied the next character when the current one ends, the block sends fill characters on its own and raises `tx_emt`. The fill is one sync character, a pair of two sync characters, or a DLE followed by the first sync character, depending on the fill mode.

In transparent mode a character equal to the DLE register is sent twice. A one-shot send-DLE command puts one DLE ahead of the next CPU character. When that command is pending and the next character is itself a DLE, only a single extra DLE is added. Dropping enable or clear-to-send takes effect only at a character boundary: the character in flight is completed, any pending second half of a pair is dropped, and `txd` then holds mark (high).

The sequencer is a state machine whose state names the kind of character in the shift register:
- `ST_IDLE` means the line is at mark.
- `ST_PREFIX` means a DLE prefix is being sent.
- `ST_DATA` means a CPU character is being sent.
- `ST_STUFF` means a stuffed DLE is being sent.
- `ST_FILL_A` and `ST_FILL_B` are the first and second fill characters.

Transitions happen only on a strobe that finds the shift register empty. They are taken in this priority order:
1. Any state goes to `ST_IDLE` when the link is stopped.
2. A pending pair half goes to `ST_FILL_B` or `ST_STUFF`.
3. A pending send-DLE command with a loaded character goes to `ST_PREFIX`.
4. A loaded character goes to `ST_DATA`.
5. An empty holding register after start-up goes to `ST_FILL_A`.
6. Otherwise the block goes to `ST_IDLE`.

Top module: `sync_fill_tx`

## Requirements
- R1: After reset, and after enabling with no character yet loaded, `txd` is 1 on every strobe, `tx_rdy` is 1 while enabled, and `tx_emt` is 0.
- R2: A loaded character starts on the first strobe that finds the shift register empty. Its data bits go out one per strobe, LSB first. The number of data bits is 5 + `char_len` (`char_len` 0 to 3). Consecutive characters follow with no idle bit between them.
- R3: With `par_en`=1, one parity bit follows the data bits. With `par_odd`=0 it is the XOR of the data bits (even parity). With `par_odd`=1 it is the inverse (odd parity).
- R4: If the holding register is empty at a boundary after the first character, fill is sent and `tx_emt` rises. The fill depends on `fill_mode`:
  - `fill_mode`=00 (and 11): `syn1`.
  - `fill_mode`=01: `syn1` then `syn2`.
  - `fill_mode`=10: `dle` then `syn1`.
- R5: Once the first character of a fill pair has started, its second character follows it directly, even if a character has been loaded in the meantime.
- R6: With `fill_mode`=10, a loaded character equal to `dle` is sent twice in a row.
- R7: A pulse on `send_dle` arms a one-shot command. The command sends `dle` before the next loaded character and is then cleared. Fill characters do not consume it.
- R8: If the command is armed when a `dle` character is sent in mode 10, exactly two DLE characters go out in total: the prefix and the character itself.
- R9: `tx_emt` is 0 until a character has been sent since enable. It returns to 0 in the cycle after an accepted load, and it is 0 while `tx_en` is 0.
- R10: `tx_rdy` = `tx_en` and holding register empty. It returns to 1 the cycle after the strobe that moves the held character into the shift register. A `load` while `tx_rdy` is 0 is ignored.
- R11: If `tx_en` or `cts` is 0 at a boundary, the character in flight has already been completed. The pending pair half is dropped and `txd` holds 1. With `cts` low and `tx_en` high, fill resumes when `cts` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_stb | input | 1 | One-cycle strobe, one bit per strobe |
| tx_en | input | 1 | Transmitter enable |
| cts | input | 1 | Clear to send, active high |
| fill_mode | input | 2 | 00/11 single sync, 01 double sync, 10 transparent |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Append parity bit |
| par_odd | input | 1 | 1 odd parity, 0 even |
| syn1 | input | 8 | First sync character |
| syn2 | input | 8 | Second sync character |
| dle | input | 8 | DLE character |
| send_dle | input | 1 | Pulse arming the one-shot DLE prefix |
| load | input | 1 | Write pulse for the holding register |
| load_data | input | 8 | Character to load |
| txd | output | 1 | Serial output, idle high |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_emt | output | 1 | Fill is being inserted |

## Verification
The bench targets these corner cases:
- A load that lands while the first half of a fill pair is on the wire. A design that let data cut in would send the data with no second fill character.
- A DLE loaded in transparent mode with and without an armed prefix. A wrong design would send one DLE or three instead of two.
- A prefix command issued while the line is filling. A design whose fill consumed the command would never send the prefix.
- Dropping enable or clear-to-send mid-character. A wrong design would truncate the character or still send the dropped pair half.
- The exact strobe on which ready returns and the cycle on which `tx_emt` falls after a load. Off-by-one sequencing would show as a mismatch on those flags.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREFIX,
        ST_DATA,
        ST_STUFF,
        ST_FILL_A,
        ST_FILL_B
    } tx_state_e;

    typedef enum logic [2:0] {
        DC_HOLD,
        DC_STOP,
        DC_IDLE,
        DC_PAIR,
        DC_PREFIX,
        DC_DATA,
        DC_FILL
    } tx_dec_e;

    localparam logic [1:0] FM_DOUBLE = 2'b01;
    localparam logic [1:0] FM_TRANSP = 2'b10;

endpackage

// File: rtl/sftx_fmt.sv
module sftx_fmt #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic [DATA_W-1:0] chr,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    output logic [DATA_W:0]   bits,
    output logic [CNT_W-1:0]  nbits
);
    logic [CNT_W-1:0]  len;
    logic [DATA_W-1:0] masked;

    assign len = CNT_W'(DATA_W - 3) + CNT_W'(char_len);

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign masked[g] = chr[g] & (len > CNT_W'(g));
    end

    always_comb begin
        bits = {1'b0, masked};
        if (par_en) begin
            bits[len] = (^masked) ^ par_odd;
        end
        nbits = len + CNT_W'(par_en);
    end
endmodule

// File: rtl/sftx_shift.sv
module sftx_shift #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             take,
    input  logic [DATA_W:0]  ld_bits,
    input  logic [CNT_W-1:0] ld_nbits,
    output logic             txd,
    output logic             at_bnd
);
    logic [DATA_W:0]  sr;
    logic [CNT_W-1:0] left;

    assign at_bnd = (left == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            left <= '0;
            txd  <= 1'b1;
        end else if (bit_stb) begin
            if (left != '0) begin
                txd  <= sr[0];
                sr   <= sr >> 1;
                left <= left - CNT_W'(1);
            end else if (take) begin
                txd  <= ld_bits[0];
                sr   <= ld_bits >> 1;
                left <= ld_nbits - CNT_W'(1);
            end else begin
                txd <= 1'b1;
            end
        end
    end

    AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        left <= CNT_W'(DATA_W)); // R3

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && take) |-> at_bnd); // R2
endmodule

// File: rtl/sftx_seq.sv
module sftx_seq
    import sftx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              at_bnd,
    input  logic              tx_en,
    input  logic              cts,
    input  logic [1:0]        fill_mode,
    input  logic [DATA_W-1:0] syn1,
    input  logic [DATA_W-1:0] syn2,
    input  logic [DATA_W-1:0] dle,
    input  logic              send_dle,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              take,
    output logic [DATA_W-1:0] next_char,
    output logic              tx_rdy,
    output logic              tx_emt,
    output tx_state_e         state
);
    logic              hr_full;
    logic [DATA_W-1:0] hr_data;
    logic              dle_arm;
    logic              skip_stuff;
    logic              pend_vld;
    logic              pend_fill;
    logic [DATA_W-1:0] pend_char;
    logic              started;
    logic              emt_q;
    logic              load_ok;
    logic              need_stuff;
    tx_dec_e           dec;

    assign tx_rdy     = tx_en & ~hr_full;
    assign tx_emt     = emt_q;
    assign load_ok    = load & tx_rdy;
    assign need_stuff = (fill_mode == FM_TRANSP) && (hr_data == dle) && !skip_stuff;

    // boundary decision, in priority order
    always_comb begin
        if (!(bit_stb && at_bnd))       dec = DC_HOLD;
        else if (!(tx_en && cts))       dec = DC_STOP;
        else if (pend_vld)              dec = DC_PAIR;
        else if (hr_full && dle_arm)    dec = DC_PREFIX;
        else if (hr_full)               dec = DC_DATA;
        else if (started)               dec = DC_FILL;
        else                            dec = DC_IDLE;
    end

    // outputs to the shifter
    always_comb begin
        take      = 1'b0;
        next_char = syn1;
        unique case (dec)
            DC_PAIR: begin
                take      = 1'b1;
                next_char = pend_char;
            end
            DC_PREFIX: begin
                take      = 1'b1;
                next_char = dle;
            end
            DC_DATA: begin
                take      = 1'b1;
                next_char = hr_data;
            end
            DC_FILL: begin
                take      = 1'b1;
                next_char = (fill_mode == FM_TRANSP) ? dle : syn1;
            end
            default: begin
                take      = 1'b0;
                next_char = syn1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (dec)
                DC_STOP, DC_IDLE: state <= ST_IDLE;
                DC_PAIR:          state <= pend_fill ? ST_FILL_B : ST_STUFF;
                DC_PREFIX:        state <= ST_PREFIX;
                DC_DATA:          state <= ST_DATA;
                DC_FILL:          state <= ST_FILL_A;
                default:          state <= state;
            endcase
        end
    end

    // holding register, command and pair bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hr_full    <= 1'b0;
            hr_data    <= '0;
            dle_arm    <= 1'b0;
            skip_stuff <= 1'b0;
            pend_vld   <= 1'b0;
            pend_fill  <= 1'b0;
            pend_char  <= '0;
            started    <= 1'b0;
            emt_q      <= 1'b0;
        end else begin
            if (load_ok) begin
                hr_full <= 1'b1;
                hr_data <= load_data;
            end
            if (send_dle) begin
                dle_arm <= 1'b1;
            end else if (dec == DC_PREFIX) begin
                dle_arm <= 1'b0;
            end
            if (!tx_en) begin
                emt_q <= 1'b0;
            end else if (load_ok) begin
                emt_q <= 1'b0;
            end else if (dec == DC_FILL) begin
                emt_q <= 1'b1;
            end
            unique case (dec)
                DC_STOP: begin
                    pend_vld <= 1'b0;
                    if (!tx_en) started <= 1'b0;
                end
                DC_PAIR: pend_vld <= 1'b0;
                DC_PREFIX: skip_stuff <= 1'b1;
                DC_DATA: begin
                    hr_full    <= 1'b0;
                    started    <= 1'b1;
                    skip_stuff <= 1'b0;
                    pend_vld   <= need_stuff;
                    pend_fill  <= 1'b0;
                    pend_char  <= dle;
                end
                DC_FILL: begin
                    pend_vld  <= (fill_mode == FM_DOUBLE) || (fill_mode == FM_TRANSP);
                    pend_fill <= 1'b1;
                    pend_char <= (fill_mode == FM_TRANSP) ? syn1 : syn2;
                end
                default: begin
                end
            endcase
        end
    end

    AST_EMT_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        tx_emt |-> started); // R9

    AST_LOAD_CLEARS_EMT: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> !tx_emt); // R9

    AST_RDY_AFTER_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DC_DATA && tx_en) |=> (tx_rdy || !tx_en)); // R10
endmodule

// File: rtl/sync_fill_tx.sv
module sync_fill_tx
    import sftx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              tx_en,
    input  logic              cts,
    input  logic [1:0]        fill_mode,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DATA_W-1:0] syn1,
    input  logic [DATA_W-1:0] syn2,
    input  logic [DATA_W-1:0] dle,
    input  logic              send_dle,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_emt
);
    localparam int CNT_W = $clog2(DATA_W + 2);

    logic              take;
    logic              at_bnd;
    logic [DATA_W-1:0] next_char;
    logic [DATA_W:0]   ld_bits;
    logic [CNT_W-1:0]  ld_nbits;
    tx_state_e         state;

    sftx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .at_bnd    (at_bnd),
        .tx_en     (tx_en),
        .cts       (cts),
        .fill_mode (fill_mode),
        .syn1      (syn1),
        .syn2      (syn2),
        .dle       (dle),
        .send_dle  (send_dle),
        .load      (load),
        .load_data (load_data),
        .take      (take),
        .next_char (next_char),
        .tx_rdy    (tx_rdy),
        .tx_emt    (tx_emt),
        .state     (state)
    );

    sftx_fmt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fmt (
        .chr      (next_char),
        .char_len (char_len),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .bits     (ld_bits),
        .nbits    (ld_nbits)
    );

    sftx_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .take     (take),
        .ld_bits  (ld_bits),
        .ld_nbits (ld_nbits),
        .txd      (txd),
        .at_bnd   (at_bnd)
    );

    AST_MARK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> txd); // R11

    AST_FILL_B_FOLLOWS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL_B) |-> ($past(state) == ST_FILL_A || $past(state) == ST_FILL_B)); // R5

    AST_STUFF_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STUFF) |-> ($past(state) == ST_DATA || $past(state) == ST_STUFF)); // R6
endmodule

// File: tb/sync_fill_tx_tb.sv
module sync_fill_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic       tx_en = 1'b0;
    logic       cts = 1'b1;
    logic [1:0] fill_mode = 2'b00;
    logic [1:0] char_len = 2'b11;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [7:0] syn1 = 8'h16;
    logic [7:0] syn2 = 8'h26;
    logic [7:0] dle = 8'h10;
    logic       send_dle = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic       txd;
    logic       tx_rdy;
    logic       tx_emt;

    always #2.5 clk = ~clk;

    sync_fill_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .tx_en(tx_en), .cts(cts),
        .fill_mode(fill_mode), .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .syn1(syn1), .syn2(syn2), .dle(dle), .send_dle(send_dle), .load(load),
        .load_data(load_data), .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state
    bit         m_hr_full, m_arm, m_skip, m_pend, m_pend_fill, m_started, m_emt;
    logic [7:0] m_hr, m_pend_char;
    logic [8:0] m_sr;
    int         m_left;
    bit         m_txd;
    bit         m_par;
    string      m_tag;

    task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic m_reset();
        m_hr_full = 0; m_arm = 0; m_skip = 0; m_pend = 0; m_pend_fill = 0;
        m_started = 0; m_emt = 0; m_hr = 0; m_pend_char = 0; m_sr = 0;
        m_left = 0; m_txd = 1; m_par = 0; m_tag = "R1";
    endtask

    task automatic m_send(input logic [7:0] c, input string tag);
        int L;
        bit p;
        logic [8:0] b;
        L = 5 + int'(char_len);
        b = '0;
        p = 0;
        for (int i = 0; i < L; i++) begin
            b[i] = c[i];
            p ^= c[i];
        end
        if (par_en) b[L] = p ^ par_odd;
        m_par = par_en;
        m_txd = b[0];
        m_sr = b >> 1;
        m_left = L + int'(par_en) - 1;
        m_tag = tag;
    endtask

    // model of one strobe edge
    task automatic m_strobe();
        if (!tx_en) m_emt = 0;
        if (m_left > 0) begin
            m_txd = m_sr[0];
            m_sr = m_sr >> 1;
            m_left--;
            if (m_left == 0 && m_par) m_tag = "R3";
        end else if (!(tx_en && cts)) begin
            m_txd = 1; m_pend = 0; m_tag = "R11";
            if (!tx_en) m_started = 0;
        end else if (m_pend) begin
            m_pend = 0;
            m_send(m_pend_char, m_pend_fill ? "R5" : "R6");
        end else if (m_hr_full && m_arm) begin
            m_arm = 0; m_skip = 1;
            m_send(dle, "R7");
        end else if (m_hr_full) begin
            string t;
            t = "R2";
            if (fill_mode == 2'b10 && m_hr == dle) begin
                if (!m_skip) begin
                    m_pend = 1; m_pend_fill = 0; m_pend_char = dle;
                end else t = "R8";
            end
            m_hr_full = 0; m_started = 1; m_skip = 0;
            m_send(m_hr, t);
        end else if (m_started) begin
            m_emt = 1;
            if (fill_mode == 2'b01) begin
                m_pend = 1; m_pend_fill = 1; m_pend_char = syn2;
            end else if (fill_mode == 2'b10) begin
                m_pend = 1; m_pend_fill = 1; m_pend_char = syn1;
            end
            m_send(fill_mode == 2'b10 ? dle : syn1, "R4");
        end else begin
            m_txd = 1; m_tag = "R1";
        end
    endtask

    task automatic m_apply(input bit do_load, input logic [7:0] d, input bit do_dle);
        bit acc;
        acc = do_load && tx_en && !m_hr_full;
        if (acc) begin
            m_hr_full = 1; m_hr = d;
        end
        if (do_dle) m_arm = 1;
        if (!tx_en || acc) m_emt = 0;
    endtask

    task automatic slot(input bit do_load, input logic [7:0] d, input bit do_dle);
        @(negedge clk);
        bit_stb = 1'b1;
        m_strobe();
        @(negedge clk);
        bit_stb = 1'b0;
        chk(txd == m_txd, m_tag, int'(txd), int'(m_txd), "txd");
        load = do_load;
        load_data = d;
        send_dle = do_dle;
        m_apply(do_load, d, do_dle);
        @(negedge clk);
        load = 1'b0;
        send_dle = 1'b0;
        chk(tx_rdy == (tx_en && !m_hr_full), "R10", int'(tx_rdy), int'(tx_en && !m_hr_full), "tx_rdy");
        chk(tx_emt == m_emt, "R9", int'(tx_emt), int'(m_emt), "tx_emt");
    endtask

    task automatic idle_slots(input int n);
        for (int i = 0; i < n; i++) slot(1'b0, 8'h00, 1'b0);
    endtask

    task automatic new_phase(input logic [1:0] fm, input logic [1:0] cl, input bit pe, input bit po);
        tx_en = 1'b0;
        idle_slots(12);
        fill_mode = fm; char_len = cl; par_en = pe; par_odd = po;
        syn1 = 8'($urandom); syn2 = 8'($urandom); dle = 8'($urandom);
        cts = 1'b1;
        tx_en = 1'b1;
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            bit dl, dd;
            logic [7:0] d;
            dl = ($urandom % 100) < 40;
            d = (($urandom % 5) == 0) ? dle : 8'($urandom);
            dd = ($urandom % 20) == 0;
            if (($urandom % 50) == 0) cts = ~cts;
            if (tx_en) begin
                if (($urandom % 90) == 0) tx_en = 1'b0;
            end else if (($urandom % 4) == 0) tx_en = 1'b1;
            slot(dl, d, dd);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        m_reset();
        repeat (4) @(negedge clk);
        // reset state
        chk(txd == 1'b1, "R1", int'(txd), 1, "txd in reset");
        chk(tx_rdy == 1'b0, "R10", int'(tx_rdy), 0, "tx_rdy in reset");
        chk(tx_emt == 1'b0, "R9", int'(tx_emt), 0, "tx_emt in reset");
        rst_n = 1'b1;
        idle_slots(2);

        // R1: enabled, nothing loaded: mark, ready, not empty-flag
        tx_en = 1'b1;
        idle_slots(6);
        // R2/R4: one character then single-sync fill
        slot(1'b1, 8'hA5, 1'b0);
        idle_slots(30);
        // R10: load while full is ignored
        slot(1'b1, 8'h3C, 1'b0);
        slot(1'b1, 8'hFF, 1'b0);
        idle_slots(24);

        // R5: double fill, load during first fill character
        new_phase(2'b01, 2'b11, 1'b1, 1'b0);
        slot(1'b1, 8'h5A, 1'b0);
        idle_slots(9);
        slot(1'b1, 8'hC3, 1'b0);
        idle_slots(40);

        // R6/R7/R8: transparent, stuffing and prefix
        new_phase(2'b10, 2'b11, 1'b0, 1'b0);
        slot(1'b1, dle, 1'b0);
        idle_slots(20);
        slot(1'b0, 8'h00, 1'b1);
        idle_slots(12);
        slot(1'b1, dle, 1'b0);
        idle_slots(30);
        slot(1'b0, 8'h00, 1'b1);
        slot(1'b1, 8'h41, 1'b0);
        idle_slots(30);

        // R11: drop enable and cts mid-character
        new_phase(2'b01, 2'b00, 1'b1, 1'b1);
        slot(1'b1, 8'h1F, 1'b0);
        slot(1'b0, 8'h00, 1'b0);
        idle_slots(2);
        cts = 1'b0;
        idle_slots(20);
        cts = 1'b1;
        idle_slots(14);
        tx_en = 1'b0;
        idle_slots(12);
        tx_en = 1'b1;
        idle_slots(8);

        // random phases
        for (int ph = 0; ph < 8; ph++) begin
            new_phase(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
            random_run(400);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule